// File: doc/BRIEF.md
# Burst-Four Quad-Rate SRAM Port Model

This block is a synthesizable model of a quad-data-rate static memory port. It has one shared block address, an independent read command and write command, a write data bus and a read data bus. Each accepted command moves four data words. Because the read and write data paths are separate, a read and a write may both be accepted on the same input-clock rising edge. Each word is a set of nine-bit lanes, and each lane has its own active-low write enable for every beat.

The model runs from one internal clock `clk` at twice the input-clock rate. The `k_rise` input tells the block which `clk` edges are the input-clock rising edges (`k_rise` high). The other edges, with `k_rise` low, are the complementary-phase edges. Commands and the address are sampled only on `k_rise` edges. Write data and lane enables are taken on every edge of a write burst. The array is addressed by `{addr, beat}`: the external address selects an aligned block of four words, and the two low bits give the beat index.

A read returns its four words on four consecutive `clk` edges. The first word arrives one and a half input-clock periods after the command, on a complementary-phase edge, so that words one and three fall on that phase and words two and four fall on the true phase. `rvalid` marks every driven word.

Top module: `qdr_burst4_sram`

## Requirements
- R1: After reset `rvalid` is 0, `rdata` is 0 and every array word reads back as 0.
- R2: `rd_n` and `wr_n` are sampled only on edges with `k_rise` high. A low level on an edge with `k_rise` low starts nothing, and when both are high the address is unused.
- R3: After a read is accepted, the `rd_n` level at the next `k_rise` edge is ignored, so reads start at most every second input-clock period.
- R4: After a write is accepted, the `wr_n` level at the next `k_rise` edge is ignored, so writes start at most every second input-clock period.
- R5: A write accepted on edge n stores the `wdata` words presented on edges n, n+1, n+2 and n+3 into words `{addr,0}` through `{addr,3}`, in that order.
- R6: `bw_n[i]` covers bits `9*i+8 : 9*i` of a beat. Lane i is written when `bw_n[i]` is 0. When `bw_n[i]` is 1, lane i keeps its stored value.
- R7: A read accepted on edge n drives words `{addr,0}` through `{addr,3}` on `rdata` with `rvalid` high. The words appear in that order, updated on edges n+3, n+4, n+5 and n+6. The first word therefore appears on an edge with `k_rise` low.
- R8: On any edge that drives no read word, `rvalid` is 0 and `rdata` is 0.
- R9: If a read and a write to the same block are accepted on the same edge, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the input-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_rise | input | 1 | High on the `clk` edges that are input-clock rising edges; alternates every edge |
| rd_n | input | 1 | Active-low read command |
| wr_n | input | 1 | Active-low write command |
| addr | input | ADDR_W | Block address of four aligned words |
| wdata | input | LANES*LANE_W | Write data beat |
| bw_n | input | LANES | Active-low per-lane write enables, one per beat |
| rdata | output | LANES*LANE_W | Read data beat |
| rvalid | output | 1 | High while `rdata` carries a read word |

## Verification
The case of interest is a read and a write accepted on the same input-clock edge. The read must see the block as it was before the write, even though the write's first beat lands on that same edge. This case is provoked directly with full-lane and partial-lane writes. It also occurs many times in a long random run: the address space is small and the commands are dense, so the read and write often target the same block. In both cases the bench judges the four returned words against a reference array. That reference takes the read words before it applies the write beats of the same edge.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
   localparam int BURST_LEN = 4;
   localparam int BEAT_W    = $clog2(BURST_LEN);
endpackage

// File: rtl/qdr_cmd_gate.sv
module qdr_cmd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic k_rise,
   input  logic cmd_n,
   output logic acc
);
   logic lock;

   assign acc = k_rise && !cmd_n && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock <= 1'b0;
      else if (k_rise) lock <= acc;
   end

   // R3 R4
   gate_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !acc ##1 !acc);
endmodule

// File: rtl/qdr_wr_seq.sv
module qdr_wr_seq
   import qdr_pkg::*;
#(
   parameter int ADDR_W = 4,
   localparam int WORD_AW = ADDR_W + BEAT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc,
   input  logic [ADDR_W-1:0]  addr,
   output logic               we,
   output logic [WORD_AW-1:0] wword
);
   logic              act;
   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] cnt;

   assign we    = acc || act;
   assign wword = acc ? {addr, {BEAT_W{1'b0}}} : {base, cnt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         base <= '0;
         cnt  <= '0;
      end else if (acc) begin
         act  <= 1'b1;
         base <= addr;
         cnt  <= BEAT_W'(1);
      end else if (act) begin
         cnt <= cnt + 1'b1;
         if (cnt == BEAT_W'(BURST_LEN - 1)) act <= 1'b0;
      end
   end

   // R5
   wr_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> we ##1 we ##1 we ##1 we);
endmodule

// File: rtl/qdr_store.sv
module qdr_store
   import qdr_pkg::*;
#(
   parameter int   LANES     = 2,
   parameter int   LANE_W    = 9,
   parameter int   ADDR_W    = 4,
   parameter bit   RESET_MEM = 1'b1,
   localparam int  DW        = LANES * LANE_W,
   localparam int  WORD_AW   = ADDR_W + BEAT_W,
   localparam int  WORDS     = 1 << WORD_AW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [WORD_AW-1:0]       wword,
   input  logic [DW-1:0]            wdata,
   input  logic [LANES-1:0]         bw_n,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [BURST_LEN*DW-1:0]  blk
);
   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] cur;
   logic [DW-1:0] merged;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("qdr_store: lane count and lane width must be positive");
   end

   assign cur = mem[wword];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] =
         bw_n[l] ? cur[l*LANE_W +: LANE_W] : wdata[l*LANE_W +: LANE_W];
   end

   for (genvar b = 0; b < BURST_LEN; b++) begin : g_blk
      assign blk[b*DW +: DW] = mem[{raddr, BEAT_W'(b)}];
   end

   if (RESET_MEM) begin : g_rst_mem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
         end else if (we) begin
            mem[wword] <= merged;
         end
      end
   end else begin : g_plain_mem
      always_ff @(posedge clk) begin
         if (we) mem[wword] <= merged;
      end
   end
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
   import qdr_pkg::*;
#(
   parameter int DW = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    k_rise,
   input  logic                    acc,
   input  logic [BURST_LEN*DW-1:0] blk,
   output logic [DW-1:0]           rdata,
   output logic                    rvalid
);
   logic [BURST_LEN*DW-1:0] snap;
   logic [BURST_LEN*DW-1:0] obuf;
   logic [2:0]              tk;
   logic                    oact;
   logic [BEAT_W-1:0]       obeat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap   <= '0;
         obuf   <= '0;
         tk     <= '0;
         oact   <= 1'b0;
         obeat  <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         if (acc)   snap <= blk;
         tk <= {tk[1:0], acc};
         if (tk[1]) obuf <= snap;
         if (tk[2]) begin
            rdata  <= obuf[DW-1:0];
            rvalid <= 1'b1;
            oact   <= 1'b1;
            obeat  <= BEAT_W'(1);
         end else if (oact) begin
            rdata  <= obuf[int'(obeat)*DW +: DW];
            rvalid <= 1'b1;
            obeat  <= obeat + 1'b1;
            if (obeat == BEAT_W'(BURST_LEN - 1)) oact <= 1'b0;
         end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
         end
      end
   end

   // R7
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ##4 rvalid);
   // R7
   rd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid);
   // R7
   rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> !$past(k_rise));
   // R8
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> rdata == '0);
endmodule

// File: rtl/qdr_burst4_sram.sv
module qdr_burst4_sram
   import qdr_pkg::*;
#(
   parameter int  LANES     = 2,
   parameter int  LANE_W    = 9,
   parameter int  ADDR_W    = 4,
   parameter bit  RESET_MEM = 1'b1,
   localparam int DW        = LANES * LANE_W,
   localparam int WORD_AW   = ADDR_W + BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              k_rise,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic [LANES-1:0]  bw_n,
   output logic [DW-1:0]     rdata,
   output logic              rvalid
);
   logic                    rd_acc;
   logic                    wr_acc;
   logic                    we;
   logic [WORD_AW-1:0]      wword;
   logic [BURST_LEN*DW-1:0] blk;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("qdr_burst4_sram: ADDR_W must lie in 1..16");
   end

   qdr_cmd_gate u_rd_gate (
      .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .cmd_n(rd_n), .acc(rd_acc)
   );

   qdr_cmd_gate u_wr_gate (
      .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .cmd_n(wr_n), .acc(wr_acc)
   );

   qdr_wr_seq #(.ADDR_W(ADDR_W)) u_wr_seq (
      .clk(clk), .rst_n(rst_n), .acc(wr_acc), .addr(addr),
      .we(we), .wword(wword)
   );

   qdr_store #(
      .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .RESET_MEM(RESET_MEM)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .wword(wword), .wdata(wdata),
      .bw_n(bw_n), .raddr(addr), .blk(blk)
   );

   qdr_rd_pipe #(.DW(DW)) u_rd_pipe (
      .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .acc(rd_acc), .blk(blk),
      .rdata(rdata), .rvalid(rvalid)
   );

   // R2
   k_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      k_rise != $past(k_rise));
endmodule

// File: tb/qdr_burst4_sram_bench.sv
module qdr_burst4_sram_bench;
   localparam int AW = 4;
   localparam int LN = 2;
   localparam int LW = 9;
   localparam int DW = LN * LW;
   localparam int NW = 1 << (AW + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          k_rise = 1'b0;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [LN-1:0] bw_n = '1;
   logic [DW-1:0] rdata;
   logic          rvalid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DW-1:0] mem_m [NW];
   bit            sv [16];
   logic [DW-1:0] sd [16];
   bit            rlock, wlock, wact, kn;
   logic [AW-1:0] wbase;
   int            wcnt;
   int            ec;

   qdr_burst4_sram u_qdr_burst4_sram (
      .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rvalid(rvalid)
   );

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                           logic [LN-1:0] bw);
      logic [DW-1:0] r = old;
      for (int l = 0; l < LN; l++)
         if (!bw[l]) r[l*LW +: LW] = nw[l*LW +: LW];
      return r;
   endfunction

   task automatic check(string tag, logic [DW-1:0] got_d, logic got_v,
                        logic [DW-1:0] exp_d, logic exp_v);
      checks++;
      if (got_d !== exp_d || got_v !== exp_v) begin
         fails++;
         $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                  tag, got_v, got_d, exp_v, exp_d);
      end
   endtask

   // one clk edge: drive at negedge, model at posedge, compare at next negedge
   task automatic step(logic rd, logic wr, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic [LN-1:0] bw, string tag);
      bit racc, wacc;
      int idx;
      k_rise = kn; rd_n = rd; wr_n = wr; addr = a; wdata = d; bw_n = bw;
      @(posedge clk);
      racc = 1'b0; wacc = 1'b0;
      if (kn) begin
         racc = !rd && !rlock; rlock = racc;
         wacc = !wr && !wlock; wlock = wacc;
      end
      if (racc)   // R9: words taken before this edge's write beat
         for (int i = 0; i < 4; i++) begin
            sv[(ec + 3 + i) % 16] = 1'b1;
            sd[(ec + 3 + i) % 16] = mem_m[a * 4 + i];
         end
      if (wacc) begin wact = 1'b1; wbase = a; wcnt = 0; end
      if (wact) begin
         idx = wbase * 4 + wcnt;
         mem_m[idx] = merge(mem_m[idx], d, bw);
         wcnt++;
         if (wcnt == 4) wact = 1'b0;
      end
      @(negedge clk);
      check(tag, rdata, rvalid, sv[ec % 16] ? sd[ec % 16] : '0, sv[ec % 16]);
      sv[ec % 16] = 1'b0;
      ec++;
      kn = ~kn;
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, AW'($urandom), DW'($urandom), LN'($urandom), tag);
   endtask

   task automatic to_k();
      if (!kn) idle(1, "R8");
   endtask

   initial begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < NW; i++) mem_m[i] = '0;
      for (int i = 0; i < 16; i++) begin sv[i] = 1'b0; sd[i] = '0; end
      rlock = 0; wlock = 0; wact = 0; wbase = '0; wcnt = 0; ec = 0;
      kn = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); k_rise = kn; kn = ~kn;
      end
      @(negedge clk);
      check("R1", rdata, rvalid, '0, 1'b0);
      k_rise = kn; kn = ~kn;
      rst_n = 1'b1;
      @(negedge clk);
      // kn is now 1: first post-reset edge driven here is a K rising edge
      // R1: every block reads zero
      for (int b = 0; b < (1 << AW); b++) begin
         to_k();
         step(1'b0, 1'b1, AW'(b), '0, '1, "R1");
         idle(3, "R1");
      end
      idle(8, "R1");
      // R5: full write then read back
      to_k();
      step(1'b1, 1'b0, 4'd2, 18'h1_0001, 2'b00, "R5");
      step(1'b1, 1'b1, 4'd9, 18'h2_0202, 2'b00, "R5");
      step(1'b1, 1'b1, 4'd9, 18'h3_0303, 2'b00, "R5");
      step(1'b1, 1'b1, 4'd9, 18'h0_4404, 2'b00, "R5");
      step(1'b0, 1'b1, 4'd2, '0, '1, "R5");
      idle(8, "R5");
      // R6: only the upper lane written, lower lane keeps its value
      step(1'b1, 1'b0, 4'd2, 18'h3_FFFF, 2'b01, "R6");
      step(1'b1, 1'b1, 4'd0, 18'h2_AAAA, 2'b10, "R6");
      step(1'b1, 1'b1, 4'd0, 18'h1_5555, 2'b11, "R6");
      step(1'b1, 1'b1, 4'd0, 18'h0_1234, 2'b00, "R6");
      step(1'b0, 1'b1, 4'd2, '0, '1, "R6");
      idle(8, "R6");
      // R9: same-edge read and write of one block
      step(1'b0, 1'b0, 4'd2, 18'h0_0F0F, 2'b00, "R9");
      step(1'b1, 1'b1, 4'd2, 18'h1_1F1F, 2'b00, "R9");
      step(1'b1, 1'b1, 4'd2, 18'h2_2F2F, 2'b10, "R9");
      step(1'b1, 1'b1, 4'd2, 18'h3_3F3F, 2'b00, "R9");
      step(1'b0, 1'b1, 4'd2, '0, '1, "R9");
      idle(8, "R9");
      // R3: read held low on every edge
      for (int i = 0; i < 12; i++) step(1'b0, 1'b1, AW'(i), '0, '1, "R3");
      idle(8, "R3");
      // R4: write held low on every edge, then read the blocks back
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0, AW'(5 + i / 2), DW'($urandom), 2'b00, "R4");
      for (int b = 5; b < 11; b++) begin
         to_k();
         step(1'b0, 1'b1, AW'(b), '0, '1, "R4");
         idle(3, "R4");
      end
      idle(8, "R4");
      // R2: commands offered only on complementary-phase edges
      for (int i = 0; i < 12; i++) begin
         to_k();
         idle(1, "R2");
         step(1'b0, 1'b0, AW'(i), DW'($urandom), 2'b00, "R2");
      end
      idle(8, "R2");
      // R7 R8: random mix
      for (int i = 0; i < 4000; i++)
         step(($urandom % 3) == 0 ? 1'b1 : 1'b0, ($urandom % 3) == 0 ? 1'b1 : 1'b0,
              AW'($urandom % 4), DW'($urandom), LN'($urandom), "R7/R8");
      idle(10, "R8");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule